// File: doc/BRIEF.md
# Accelerator Command and Response Controller

This block is the control front end of a streaming-command accelerator. Software or an upstream agent starts the block with a one-cycle request while it reports idle. It then pushes a six-word command packet over an inbound 32-bit AXI4-Stream port. The first word is a transaction tag. It is followed by three element-index offsets (input, coefficient, output) and two job dimensions (rows, columns). Each offset is added to a shared element-index memory base to form the three pointers handed to a compute engine.

Once the last word arrives, the column count is compared with the filter tap count. A job that is too narrow is answered at once with an error response, and the engine is never touched. A valid job launches the engine with a single-cycle start pulse. The block then waits for the engine's done pulse and returns a tagged completion word on an outbound 32-bit AXI4-Stream port. The inbound port stays closed from the last command word until the response has been taken, so commands never overlap. A one-cycle done pulse marks the end of each transaction, and the block then returns to idle.

Top module: `job_cmd_ctrl`

## Requirements
- R1: After reset, `blk_idle` is 1 and `cmd_tready`, `rsp_tvalid`, `eng_start` and `blk_done` are all 0.
- R2: While idle, `cmd_tready` stays 0 and offered words are not consumed. The cycle after `blk_start` is seen in idle, `blk_idle` drops and `cmd_tready` rises.
- R3: Word order is tag, input offset, coefficient offset, output offset, rows, columns. `eng_x_addr`, `eng_h_addr` and `eng_y_addr` equal `mem_base` plus the matching offset, modulo 2^32. `eng_rows` and `eng_cols` carry the dimensions. All five values hold steady until the response.
- R4: For a valid command, `eng_start` is high for exactly one cycle, in the cycle after the sixth word is accepted.
- R5: If the column count is below TAPS (8, unsigned), no start pulse is issued. The response is valid in the cycle after the sixth word, with bit 31 set.
- R6: The response word is bit 31 = error, bits 30:16 = 0, and bits 15:0 = bits 15:0 of the tag word. For a valid command, `rsp_tvalid` rises only in the cycle after `eng_done` is seen.
- R7: `cmd_tready` is 0 from the cycle after the sixth word until the block is started again.
- R8: Once `rsp_tvalid` is 1, it and `rsp_tdata` hold unchanged until `rsp_tready` is seen.
- R9: In the cycle after the response handshake, `blk_done` is 1 for one cycle, `blk_idle` is 1 and `rsp_tvalid` is 0.
- R10: An `eng_done` in the same cycle as `eng_start` counts as completion, and the response is valid in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blk_start | input | 1 | Request to accept one command; taken while idle |
| blk_idle | output | 1 | Block is waiting for a start request |
| blk_done | output | 1 | One-cycle pulse after the response is taken |
| mem_base | input | 32 | Shared element-index base of memory |
| cmd_tdata | input | 32 | Inbound command word |
| cmd_tvalid | input | 1 | Inbound word valid |
| cmd_tready | output | 1 | Inbound word accepted this cycle |
| rsp_tdata | output | 32 | Outbound response word |
| rsp_tvalid | output | 1 | Outbound response valid |
| rsp_tready | input | 1 | Outbound response accepted |
| eng_start | output | 1 | One-cycle engine launch pulse |
| eng_done | input | 1 | Engine completion pulse |
| eng_x_addr | output | 32 | Input pointer, in elements |
| eng_h_addr | output | 32 | Coefficient pointer, in elements |
| eng_y_addr | output | 32 | Output pointer, in elements |
| eng_rows | output | 32 | Row count of the job |
| eng_cols | output | 32 | Column count of the job |

## Verification
Launch and completion can fall in the same cycle. An engine that answers with zero latency raises `eng_done` while `eng_start` is still high. The bench stub has a latency setting swept from zero upward to provoke this. Each case is judged by the exact cycle at which `rsp_tvalid` appears (one cycle after launch for zero latency), by a single launch count, and by the tag carried in the response. The sweep also crosses latency with narrow and wide column counts and with response back-pressure.

// File: rtl/jcc_pkg.sv
// Shared constants and types of the command controller.
// Assumes a fixed six-word command packet.
package jcc_pkg;
    localparam int CMD_WORDS = 6;
    localparam int ARG_WORDS = CMD_WORDS - 1;
    // Argument slots follow the tag word in arrival order
    localparam int ARG_X    = 0;
    localparam int ARG_H    = 1;
    localparam int ARG_Y    = 2;
    localparam int ARG_ROWS = 3;
    localparam int ARG_COLS = 4;
    localparam int NUM_PTRS = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_LAUNCH,
        ST_WAIT,
        ST_RESP
    } ctl_state_t;
endpackage

// File: rtl/jcc_capture.sv
// Command word sequencer and field store.
// Counts accepted beats, keeps the tag and the five argument words.
// Assumes 'clear' is asserted at the start of each packet.
module jcc_capture #(
    parameter int W    = 32,
    parameter int ID_W = 16
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  clear,
    input  logic                                  beat,
    input  logic [W-1:0]                          data,
    output logic                                  last_beat,
    output logic [ID_W-1:0]                       tag,
    output logic [jcc_pkg::ARG_WORDS-1:0][W-1:0]  args
);
    localparam int CW = $clog2(jcc_pkg::CMD_WORDS);

    logic [CW-1:0] cnt;

    assign last_beat = beat && (cnt == CW'(jcc_pkg::CMD_WORDS - 1));

    // Beat counter: restarts per packet, advances on each accepted word
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (beat) begin
            cnt <= last_beat ? '0 : cnt + 1'b1;
        end
    end

    // Tag register: first word of the packet, low bits only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag <= '0;
        end else if (beat && cnt == '0) begin
            tag <= data[ID_W-1:0];
        end
    end

    // One register per argument slot
    for (genvar i = 0; i < jcc_pkg::ARG_WORDS; i++) begin : g_arg
        // Argument store: captures the word whose beat index matches the slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                args[i] <= '0;
            end else if (beat && cnt == CW'(i + 1)) begin
                args[i] <= data;
            end
        end
    end
endmodule

// File: rtl/jcc_argchk.sv
// Argument check: flags a column count too small for the tap window.
// Purely combinational; unsigned compare.
module jcc_argchk #(
    parameter int W    = 32,
    parameter int TAPS = 8
) (
    input  logic [W-1:0] cols,
    output logic         too_narrow
);
    // Window test against the tap count
    always_comb too_narrow = (cols < W'(TAPS));
endmodule

// File: rtl/jcc_rsp.sv
// Outbound response holding register.
// Keeps valid and data steady until the receiver takes the word.
// Assumes 'load' is never raised while a word is pending.
module jcc_rsp #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    output logic [W-1:0] tdata,
    output logic         tvalid,
    input  logic         tready
);
    // Valid flag: set on load, cleared on handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tvalid <= 1'b0;
        end else if (load) begin
            tvalid <= 1'b1;
        end else if (tvalid && tready) begin
            tvalid <= 1'b0;
        end
    end

    // Data register: written only on load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tdata <= '0;
        end else if (load) begin
            tdata <= load_data;
        end
    end
endmodule

// File: rtl/job_cmd_ctrl.sv
// Command and response controller of a streaming accelerator.
// Accepts one six-word command after a start request, checks it,
// launches the engine, waits for completion and returns a tagged response.
// Assumes mem_base is stable for the length of a job and eng_done only
// pulses for a launched job.
module job_cmd_ctrl #(
    parameter int W    = 32,
    parameter int ID_W = 16,
    parameter int TAPS = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         blk_start,
    output logic         blk_idle,
    output logic         blk_done,
    input  logic [W-1:0] mem_base,
    input  logic [W-1:0] cmd_tdata,
    input  logic         cmd_tvalid,
    output logic         cmd_tready,
    output logic [W-1:0] rsp_tdata,
    output logic         rsp_tvalid,
    input  logic         rsp_tready,
    output logic         eng_start,
    input  logic         eng_done,
    output logic [W-1:0] eng_x_addr,
    output logic [W-1:0] eng_h_addr,
    output logic [W-1:0] eng_y_addr,
    output logic [W-1:0] eng_rows,
    output logic [W-1:0] eng_cols
);
    import jcc_pkg::*;

    localparam int PAD_W = W - 1 - ID_W;

    ctl_state_t state, state_nx;
    logic beat, last_beat, too_narrow, rsp_load, rsp_err, done_q, rsp_take;
    logic [ID_W-1:0] tag;
    logic [ARG_WORDS-1:0][W-1:0] args;
    logic [NUM_PTRS-1:0][W-1:0] ptrs;

    assign beat       = cmd_tvalid && cmd_tready;
    assign cmd_tready = (state == ST_RECV);
    assign blk_idle   = (state == ST_IDLE);
    assign eng_start  = (state == ST_LAUNCH);
    assign blk_done   = done_q;
    assign rsp_take   = rsp_tvalid && rsp_tready;

    jcc_capture #(.W(W), .ID_W(ID_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (blk_idle && blk_start),
        .beat      (beat),
        .data      (cmd_tdata),
        .last_beat (last_beat),
        .tag       (tag),
        .args      (args)
    );

    // The column count is checked as it arrives on the last beat
    jcc_argchk #(.W(W), .TAPS(TAPS)) u_chk_args (
        .cols       (cmd_tdata),
        .too_narrow (too_narrow)
    );

    // Pointer adders: element-index base plus each offset
    for (genvar p = 0; p < NUM_PTRS; p++) begin : g_ptr
        assign ptrs[p] = mem_base + args[p];
    end

    assign eng_x_addr = ptrs[ARG_X];
    assign eng_h_addr = ptrs[ARG_H];
    assign eng_y_addr = ptrs[ARG_Y];
    assign eng_rows   = args[ARG_ROWS];
    assign eng_cols   = args[ARG_COLS];

    // Next-state and response-load decode
    always_comb begin
        state_nx = state;
        rsp_load = 1'b0;
        rsp_err  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (blk_start) state_nx = ST_RECV;
            end
            ST_RECV: begin
                if (last_beat) begin
                    if (too_narrow) begin
                        state_nx = ST_RESP;
                        rsp_load = 1'b1;
                        rsp_err  = 1'b1;
                    end else begin
                        state_nx = ST_LAUNCH;
                    end
                end
            end
            ST_LAUNCH, ST_WAIT: begin
                if (eng_done) begin
                    state_nx = ST_RESP;
                    rsp_load = 1'b1;
                end else begin
                    state_nx = ST_WAIT;
                end
            end
            ST_RESP: begin
                if (rsp_take) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Done pulse: one cycle after the response is taken
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= (state == ST_RESP) && rsp_take;
    end

    jcc_rsp #(.W(W)) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (rsp_load),
        .load_data ({rsp_err, {PAD_W{1'b0}}, tag}),
        .tdata     (rsp_tdata),
        .tvalid    (rsp_tvalid),
        .tready    (rsp_tready)
    );
endmodule

// File: rtl/job_cmd_ctrl_chk.sv
// Protocol checker for the command controller, bound to every instance.
// Tracks whether a launched job is outstanding.
module job_cmd_ctrl_chk #(
    parameter int W    = 32,
    parameter int TAPS = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         blk_idle,
    input logic         blk_done,
    input logic         cmd_tready,
    input logic         rsp_tvalid,
    input logic         rsp_tready,
    input logic [W-1:0] rsp_tdata,
    input logic         eng_start,
    input logic         eng_done,
    input logic [W-1:0] eng_x_addr,
    input logic [W-1:0] eng_cols
);
    logic busy;

    // Outstanding-job tracker
    always_ff @(posedge clk) begin
        if (!rst_n)                     busy <= 1'b0;
        else if (eng_start && !eng_done) busy <= 1'b1;
        else if (eng_done)               busy <= 1'b0;
    end

    // R4
    single_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R7
    closed_intake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !cmd_tready);

    // R5
    wide_enough_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> (eng_cols >= W'(TAPS)));

    // R6
    reply_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_tvalid |-> !busy);

    // R8
    reply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_tvalid && !rsp_tready) |=> (rsp_tvalid && $stable(rsp_tdata)));

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |-> (blk_idle && !rsp_tvalid));

    // R3
    ptr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $stable(eng_x_addr));
endmodule

bind job_cmd_ctrl job_cmd_ctrl_chk #(.W(W), .TAPS(TAPS)) u_proto_chk (.*);

// File: tb/job_cmd_ctrl_bench.sv
// Bench: sweeps engine latency, column count and response back-pressure.
module job_cmd_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        blk_start = 1'b0;
    logic        blk_idle, blk_done;
    logic [31:0] mem_base = '0;
    logic [31:0] cmd_tdata = '0;
    logic        cmd_tvalid = 1'b0;
    logic        cmd_tready;
    logic [31:0] rsp_tdata;
    logic        rsp_tvalid;
    logic        rsp_tready = 1'b0;
    logic        eng_start, eng_done;
    logic [31:0] eng_x_addr, eng_h_addr, eng_y_addr, eng_rows, eng_cols;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    bit finished = 1'b0;

    // Engine stub state
    int lat = 1;
    int cnt = 0;
    int starts = 0;
    int dones = 0;
    logic [31:0] seen_x, seen_h, seen_y, seen_r, seen_c;

    always #4 clk = ~clk;

    job_cmd_ctrl u_job_cmd_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .blk_start  (blk_start),
        .blk_idle   (blk_idle),
        .blk_done   (blk_done),
        .mem_base   (mem_base),
        .cmd_tdata  (cmd_tdata),
        .cmd_tvalid (cmd_tvalid),
        .cmd_tready (cmd_tready),
        .rsp_tdata  (rsp_tdata),
        .rsp_tvalid (rsp_tvalid),
        .rsp_tready (rsp_tready),
        .eng_start  (eng_start),
        .eng_done   (eng_done),
        .eng_x_addr (eng_x_addr),
        .eng_h_addr (eng_h_addr),
        .eng_y_addr (eng_y_addr),
        .eng_rows   (eng_rows),
        .eng_cols   (eng_cols)
    );

    // Zero latency answers in the launch cycle itself
    always_comb eng_done = (lat == 0) ? eng_start : (cnt == 1);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (eng_start && lat > 0) cnt <= lat;
        else if (cnt != 0)        cnt <= cnt - 1;
        if (eng_start) begin
            starts <= starts + 1;
            seen_x <= eng_x_addr; seen_h <= eng_h_addr; seen_y <= eng_y_addr;
            seen_r <= eng_rows;   seen_c <= eng_cols;
        end
        if (eng_done) dones <= dones + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_job(input logic [31:0] tx, input logic [31:0] base,
                           input logic [31:0] xo, input logic [31:0] ho,
                           input logic [31:0] yo, input logic [31:0] rows,
                           input logic [31:0] cols, input int lt, input int rd);
        logic [31:0] w [6];
        logic [31:0] exp_rsp;
        bit bad;
        int s0, d0, k;
        w[0] = tx; w[1] = xo; w[2] = ho; w[3] = yo; w[4] = rows; w[5] = cols;
        bad = (cols < 32'd8);
        exp_rsp = {bad, 15'b0, tx[15:0]};
        lat = lt;
        mem_base = base;
        s0 = starts;
        d0 = dones;
        // R2: word offered while idle must wait
        cmd_tvalid = 1'b1;
        cmd_tdata  = w[0];
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk(!cmd_tready && blk_idle, "R2 closed while idle", {30'b0, cmd_tready, blk_idle}, 32'h1);
        end
        blk_start = 1'b1;
        @(negedge clk);
        blk_start = 1'b0;
        chk(cmd_tready && !blk_idle, "R2 open after start", {30'b0, cmd_tready, blk_idle}, 32'h2);
        for (int i = 0; i < 6; i++) begin
            cmd_tdata  = w[i];
            cmd_tvalid = 1'b1;
            while (!cmd_tready) @(negedge clk);
            @(negedge clk);
        end
        cmd_tvalid = 1'b0;
        cmd_tdata  = '0;
        chk(!cmd_tready, "R7 closed after last word", {31'b0, cmd_tready}, 32'h0);
        k = 0;
        while (!rsp_tvalid && k < 50) begin
            @(negedge clk);
            k++;
            chk(!cmd_tready, "R7 closed while running", {31'b0, cmd_tready}, 32'h0);
        end
        if (bad) begin
            chk(k == 0, "R5 immediate response", k, 0);
            chk(starts == s0, "R5 no launch", starts - s0, 0);
        end else begin
            chk(k == 1 + lt, lt == 0 ? "R10 response cycle" : "R6 response cycle", k, 1 + lt);
            chk(starts == s0 + 1, "R4 one launch", starts - s0, 1);
            chk(dones == d0 + 1, "R6 done before response", dones - d0, 1);
            chk(seen_x == base + xo, "R3 input pointer", seen_x, base + xo);
            chk(seen_h == base + ho, "R3 coefficient pointer", seen_h, base + ho);
            chk(seen_y == base + yo, "R3 output pointer", seen_y, base + yo);
            chk(seen_r == rows && seen_c == cols, "R3 dimensions", seen_c, cols);
        end
        chk(rsp_tdata == exp_rsp, bad ? "R5 error word" : "R6 response word", rsp_tdata, exp_rsp);
        for (int j = 0; j < rd; j++) begin
            @(negedge clk);
            chk(rsp_tvalid && rsp_tdata == exp_rsp, "R8 held under back-pressure", rsp_tdata, exp_rsp);
        end
        rsp_tready = 1'b1;
        @(negedge clk);
        rsp_tready = 1'b0;
        chk(blk_done && blk_idle && !rsp_tvalid, "R9 done pulse",
            {29'b0, blk_done, blk_idle, rsp_tvalid}, 32'h6);
        @(negedge clk);
        chk(!blk_done, "R9 done is one cycle", {31'b0, blk_done}, 32'h0);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] col_set [5];
        logic [31:0] base;
        col_set[0] = 32'd5;  col_set[1] = 32'd7; col_set[2] = 32'd8;
        col_set[3] = 32'd9;  col_set[4] = 32'd33;
        repeat (3) @(negedge clk);
        // R1
        chk(blk_idle && !cmd_tready && !rsp_tvalid && !eng_start && !blk_done,
            "R1 reset state", {27'b0, blk_idle, cmd_tready, rsp_tvalid, eng_start, blk_done}, 32'h10);
        rst_n = 1'b1;
        @(negedge clk);
        chk(blk_idle && !cmd_tready && !rsp_tvalid, "R1 after release",
            {29'b0, blk_idle, cmd_tready, rsp_tvalid}, 32'h4);
        for (int lt = 0; lt < 4; lt++) begin
            for (int ci = 0; ci < 5; ci++) begin
                base = (ci == 4) ? 32'hFFFF_FFF0 : (32'h1000_0000 * lt + 32'h111 * ci);
                run_job(32'hABCD_0000 | (lt * 16 + ci), base,
                        32'h20 + ci * 7, 32'h100 + lt, 32'h4000 + ci * lt,
                        32'd2 + lt, col_set[ci], lt, (lt + ci) % 3);
            end
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule